// File: doc/BRIEF.md
# Serial Gain-Word Loader

This block is the digital control front end of a programmable attenuator. A host shifts an 8-bit gain code in one bit at a time, most significant bit first, over a slow serial clock. The bits go through a two-stage register: a rising serial-clock edge captures the current data bit into a master stage, and the following falling edge moves that bit into the slave shift register. All of this happens while an active-low load enable is held low. When the enable goes high, the assembled word is copied into a hold latch that drives the gain code, and further shifting stops. The next time the enable goes low, loading opens again while the latch keeps the old code.

Everything runs from one fast system clock. The serial clock, serial data, enable, power-control and sleep inputs all pass through two-flop synchronizers, and edges are found from the synchronized values. The gain code is a plain level output with no handshake. The latch holds its value until the next commit, so no back-pressure is possible and none is needed. The power-control input (1 = on) and the active-low sleep input are turned into two registered flags: an active flag and a low-power flag.

Top module: `gain_word_loader`

## Requirements
- R1: A full word shifted in with 8 falling serial-clock edges while the enable is low appears on `gain_o` with the first-sent bit at bit 7 after the enable rises (0xA5 sent as 1,0,1,0,0,1,0,1 gives 0xA5).
- R2: The bit taken into the word is the value of `sdata_i` at the rising serial-clock edge. A change of `sdata_i` after that rise and before the fall has no effect.
- R3: The shift register advances only on a falling serial-clock edge. A rising edge with no fall before the commit leaves the committed word equal to the previously held contents.
- R4: An enable rise copies the shift register into `gain_o`. The new value is visible on the third system-clock edge after the enable input changes.
- R5: Serial-clock edges that occur while the enable is high are ignored and leave the shift register unchanged.
- R6: `gain_o` changes only on an enable rise. While the enable is low and bits are being shifted, `gain_o` keeps its previous value.
- R7: A partial word is still committed. After a committed 0xA5, shifting the three bits 1,0,1 and raising the enable gives 0x2D.
- R8: Reset clears the shift register and the gain latch to 0x00, and drives `active_o` and `low_power_o` to 0.
- R9: `active_o` equals `pwr_on_i AND sleep_n_i`, and `low_power_o` equals `NOT sleep_n_i`. Both follow their inputs on the third system-clock edge after a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n_i | input | 1 | Active-low load enable; rising edge commits the word |
| sdata_i | input | 1 | Serial gain data, most significant bit first |
| sclk_i | input | 1 | Serial clock, both edges used |
| pwr_on_i | input | 1 | Power control, 1 = on, 0 = off |
| sleep_n_i | input | 1 | Active-low sleep request |
| gain_o | output | 8 | Latched gain code |
| active_o | output | 1 | Part powered and awake |
| low_power_o | output | 1 | Sleep state in force |

## Verification
On every cycle, the assertions check the following: the gain latch moves only on a commit and then takes the shift-register contents; the shift register stays still when no falling serial edge arrives or when loading is closed; and the two status flags never both indicate activity and sleep. Several behaviours can only be shown by the bench's scenarios, which compare against a reference model on every clock: the bit order, the sampling of data at the rise rather than the fall, commits of partial words, and the exact three-edge latency through the synchronizers.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  parameter int unsigned GAIN_W = 8;
  parameter int unsigned SYNC_STAGES = 2;
  typedef logic [GAIN_W-1:0] gain_t;
  // bit positions inside the synchronized control bundle
  localparam int unsigned B_SLEEPN = 0;
  localparam int unsigned B_PWR    = 1;
  localparam int unsigned B_SDATA  = 2;
  localparam int unsigned B_SCLK   = 3;
  localparam int unsigned B_LOADN  = 4;
  localparam int unsigned CTRL_W   = 5;
endpackage

// File: rtl/sgl_sync.sv
module sgl_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sgl_edge.sv
module sgl_edge #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/sgl_shift.sv
module sgl_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic         sample_i,
  input  logic         advance_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic master;

  // master stage: captures data on a serial-clock rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  master <= 1'b0;
    else if (open_i && sample_i) master <= din_i;
  end

  // slave stage: advances on a serial-clock fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   word_o <= '0;
    else if (open_i && advance_i) word_o <= {word_o[W-2:0], master};
  end
endmodule

// File: rtl/sgl_commit.sv
module sgl_commit #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit_i,
  input  logic         reopen_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] gain_o,
  output logic         open_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gain_o <= '0;
    else if (commit_i) gain_o <= word_i;
  end

  // loading window: opened by an enable fall, closed by a rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        open_o <= 1'b0;
    else if (reopen_i) open_o <= 1'b1;
    else if (commit_i) open_o <= 1'b0;
  end
endmodule

// File: rtl/gain_word_loader.sv
module gain_word_loader
  import sgl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_n_i,
  input  logic        sdata_i,
  input  logic        sclk_i,
  input  logic        pwr_on_i,
  input  logic        sleep_n_i,
  output logic [7:0]  gain_o,
  output logic        active_o,
  output logic        low_power_o
);
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1 << B_LOADN) | CTRL_W'(1 << B_SLEEPN);

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic [1:0]        lvl, rise, fall;
  logic              open_w;
  gain_t             word_w;
  gain_t             gain_w;

  assign ctrl_raw[B_LOADN]  = load_n_i;
  assign ctrl_raw[B_SCLK]   = sclk_i;
  assign ctrl_raw[B_SDATA]  = sdata_i;
  assign ctrl_raw[B_PWR]    = pwr_on_i;
  assign ctrl_raw[B_SLEEPN] = sleep_n_i;

  sgl_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  // lvl[1] = load enable, lvl[0] = serial clock
  assign lvl = {ctrl_s[B_LOADN], ctrl_s[B_SCLK]};

  sgl_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(lvl), .rise(rise), .fall(fall)
  );

  sgl_shift #(.W(GAIN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .open_i(open_w), .sample_i(rise[0]),
    .advance_i(fall[0]), .din_i(ctrl_s[B_SDATA]), .word_o(word_w)
  );

  sgl_commit #(.W(GAIN_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .commit_i(rise[1]), .reopen_i(fall[1]),
    .word_i(word_w), .gain_o(gain_w), .open_o(open_w)
  );

  assign gain_o = gain_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o    <= 1'b0;
      low_power_o <= 1'b0;
    end else begin
      active_o    <= ctrl_s[B_PWR] & ctrl_s[B_SLEEPN];
      low_power_o <= ~ctrl_s[B_SLEEPN];
    end
  end
endmodule

// File: rtl/gain_word_loader_chk.sv
module gain_word_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] gain_o,
  input logic       active_o,
  input logic       low_power_o,
  input logic [7:0] word,
  input logic       commit,
  input logic       sfall,
  input logic       open
);
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(gain_o)); // R6
  AST_GAIN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> gain_o == $past(word)); // R4
  AST_SHIFT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(word)); // R5
  AST_SHIFT_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !sfall |=> $stable(word)); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !low_power_o); // R9
endmodule

bind gain_word_loader gain_word_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gain_o(gain_o), .active_o(active_o),
  .low_power_o(low_power_o), .word(word_w), .commit(rise[1]),
  .sfall(fall[0]), .open(open_w)
);

// File: tb/gain_word_loader_bench.sv
module gain_word_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1, sdata = 1'b0, sclk = 1'b0, pwr_on = 1'b0, sleep_n = 1'b1;
  logic [7:0] gain;
  logic active, low_power;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_word_loader u_gain_word_loader (
    .clk(clk), .rst_n(rst_n), .load_n_i(load_n), .sdata_i(sdata), .sclk_i(sclk),
    .pwr_on_i(pwr_on), .sleep_n_i(sleep_n), .gain_o(gain), .active_o(active),
    .low_power_o(low_power)
  );

  // ---- behavioural reference model ----
  typedef struct packed { logic en; logic ck; logic sd; logic pw; logic sl; } snap_t;
  localparam snap_t IDLE = '{en:1'b1, ck:1'b0, sd:1'b0, pw:1'b0, sl:1'b1};
  snap_t hist[$];
  logic [7:0] m_sh, m_gain;
  logic m_master, m_open, m_act, m_lp;

  task automatic model_clear();
    hist = {IDLE, IDLE, IDLE};
    m_sh = 0; m_gain = 0; m_master = 0; m_open = 0; m_act = 0; m_lp = 0;
  endtask

  initial model_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      snap_t v, p;
      logic old_master;
      v = hist[1]; p = hist[2];
      old_master = m_master;
      if (!v.en && p.en) begin
        // enable falls: nothing visible changes yet
      end
      if (v.en && !p.en) m_gain = m_sh;
      if (m_open && v.ck && !p.ck) m_master = v.sd;
      if (m_open && !v.ck && p.ck) m_sh = {m_sh[6:0], old_master};
      if (!v.en && p.en) m_open = 1;
      else if (v.en && !p.en) m_open = 0;
      m_act = v.pw & v.sl;
      m_lp = ~v.sl;
      hist.push_front('{en:load_n, ck:sclk, sd:sdata, pw:pwr_on, sl:sleep_n});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (gain !== m_gain) begin
        errors++;
        $display("FAIL R4/R6 model gain: actual=%h expected=%h", gain, m_gain);
      end
      checks++;
      if (active !== m_act || low_power !== m_lp) begin
        errors++;
        $display("FAIL R9 model flags: actual=%b%b expected=%b%b", active, low_power, m_act, m_lp);
      end
    end
  end

  // ---- scenario helpers ----
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(bit b);
    sdata = b; tick(2);
    sclk = 1; tick(3);
    sclk = 0; tick(3);
  endtask

  task automatic send_bits(logic [7:0] w, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    tick(4);
    check("R8 reset gain", gain, 8'h00);
    check("R8 reset flags", {active, low_power}, 2'b00);
    rst_n = 1; tick(4);

    // R1: full word, MSB first
    load_n = 0; tick(3);
    send_bits(8'hA5, 8);
    check("R6 gain held while loading", gain, 8'h00);
    load_n = 1; tick(2);
    check("R4 not yet committed", gain, 8'h00);
    tick(1);
    check("R4 committed third edge", gain, 8'hA5);
    check("R1 full word", gain, 8'hA5);
    tick(3);

    // R7: partial word of three bits
    load_n = 0; tick(3);
    send_bits(8'h05, 3);
    load_n = 1; tick(4);
    check("R7 partial word", gain, 8'h2D);

    // R2: data changed between rise and fall is not taken
    load_n = 0; tick(3);
    for (int i = 7; i >= 0; i--) begin
      sdata = 8'h3C >> i; tick(2);
      sclk = 1; tick(3);
      sdata = ~sdata; tick(2);
      sclk = 0; tick(3);
    end
    load_n = 1; tick(4);
    check("R2 sample at rise", gain, 8'h3C);

    // R3: rise without fall before commit
    load_n = 0; tick(3);
    send_bits(8'h5A, 8);
    sdata = 1; tick(2);
    sclk = 1; tick(4);
    load_n = 1; tick(4);
    check("R3 no advance without fall", gain, 8'h5A);
    sclk = 0; tick(4);

    // R5: edges with enable high are ignored
    for (int i = 0; i < 8; i++) begin
      sdata = 1; tick(2); sclk = 1; tick(3); sclk = 0; tick(3);
    end
    check("R6 gain held while enable high", gain, 8'h5A);
    load_n = 0; tick(4);
    load_n = 1; tick(4);
    check("R5 ignored edges", gain, 8'h5A);

    // R9: status flags
    pwr_on = 1; sleep_n = 1; tick(2);
    check("R9 latency before", {active, low_power}, 2'b00);
    tick(1);
    check("R9 on awake", {active, low_power}, 2'b10);
    pwr_on = 0; tick(3);
    check("R9 off awake", {active, low_power}, 2'b00);
    pwr_on = 1; sleep_n = 0; tick(3);
    check("R9 on asleep", {active, low_power}, 2'b01);
    pwr_on = 0; tick(3);
    check("R9 off asleep", {active, low_power}, 2'b01);
    check("R6 gain unaffected by flags", gain, 8'h5A);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    done = 1;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule